// File: doc/BRIEF.md
# Home-Node Acknowledge Hazard Tracker

This block sits beside the snoop decision logic of a coherent home node. It keeps a small table of the transactions the home node is serving. Once the home node has sent the final response for a transaction that needs a completion acknowledge, it keeps the cache line of that transaction fenced off from further snooping until the requester sends its acknowledge back. New snoop-requiring requests come in on a valid/ready stream. Ready is the decision: high means the request may go ahead and takes a table slot, low means it is stalled for this cycle.

Two plain event inputs move the table. A completion event carries the source and transaction ID of the response the home node has just issued. An acknowledge event carries the source and transaction ID that the requester returned. Only the opcode class decides whether a transaction holds its line after the completion. A transaction that needs no acknowledge frees its slot at the completion. An acknowledge that matches no waiting slot is a protocol error and sets a sticky flag.

Stream rules: a request is taken in a cycle where `req_valid` and `req_ready` are both high. While it is stalled, the sender keeps `req_valid` high and holds its fields stable, and it retries in every following cycle. `req_ready` is computed from the registered table and the present request fields alone, so it does not depend on events in the same cycle.

Top module: `hn_ack_hazard`

## Requirements
- R1: After reset every slot is free, `ack_err` is 0, and a request to any line is ready.
- R2: The request opcode field `req_op` has these codes: 0 non-snooping read, 1 read-once family, 2 other coherent read, 3 unique write, 4 non-snooping write, 5 other write, 6 and 7 reserved. Codes 2, 3 and 4 make the slot hold its line after the completion. All other codes free the slot at the completion.
- R3: While some slot holds a line and waits for its acknowledge, a request to that line gets `req_ready`=0, and `req_stall`=1 when `req_valid` is high.
- R4: Lines are 64 bytes. Address bits [5:0] take no part in the comparison, and a request to a different line is not stalled by a waiting slot.
- R5: An acknowledge whose source ID and transaction ID match a waiting slot frees that slot, and its line can be requested again.
- R6: When all slots are in use, every request is stalled. Once a slot is freed, requests are ready again.
- R7: An acknowledge that matches no waiting slot sets `ack_err`. The flag stays set until reset, and no slot changes.
- R8: An acknowledge that arrives before the completion of its transaction counts as unmatched. It sets `ack_err`, and the later completion still leaves the line waiting.
- R9: A completion that matches no active slot has no effect.
- R10: A line held only by a slot whose completion has not been sent does not stall new requests.
- R11: A completion or acknowledge given in cycle t changes `req_ready` from cycle t+1 on, not in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A new snoop-requiring request is offered |
| req_ready | output | 1 | The request is allowed and takes a slot |
| req_stall | output | 1 | The offered request is held back this cycle |
| req_op | input | 3 | Opcode class (see R2) |
| req_addr | input | ADDR_W | Physical address of the request |
| req_src | input | SRC_W | Requester node ID |
| req_txn | input | TXN_W | Transaction ID of the request |
| cmp_valid | input | 1 | The home node issued a completion |
| cmp_src | input | SRC_W | Requester ID of the completed transaction |
| cmp_txn | input | TXN_W | Transaction ID of the completed transaction |
| ack_valid | input | 1 | A completion acknowledge arrived |
| ack_src | input | SRC_W | Source ID on the acknowledge |
| ack_txn | input | TXN_W | Transaction ID on the acknowledge |
| ack_err | output | 1 | Sticky flag for an unmatched acknowledge |

## Verification
The bench tries the hazard decision with these patterns:
- Same-line requests with different low address bits, set against requests one line away. This separates line matching from full-address matching.
- Requests to a line whose completion is still pending, set against requests to a line already waiting for its acknowledge. This separates the two busy states.
- A sweep over all eight opcode codes, each followed by its completion. This shows which classes hold the line.
- A completion or acknowledge given in the same cycle as a stalled request. This pins down the one-cycle delay before the change shows.
- A stray acknowledge, an early acknowledge, an unknown completion and a completely full table. These show that errors and capacity stalls leave the table itself unchanged.

// File: rtl/hn_ack_hazard_pkg.sv
package hn_ack_hazard_pkg;

  typedef enum logic [2:0] {
    OPC_RD_NOSNP  = 3'd0,
    OPC_RD_ONCE   = 3'd1,
    OPC_RD_COH    = 3'd2,
    OPC_WR_UNIQUE = 3'd3,
    OPC_WR_NOSNP  = 3'd4,
    OPC_WR_OTHER  = 3'd5,
    OPC_RSVD6     = 3'd6,
    OPC_RSVD7     = 3'd7
  } opc_class_e;

  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_ACTIVE = 2'd1,
    SLOT_WAIT   = 2'd2
  } slot_state_e;

  function automatic logic opc_needs_ack(opc_class_e op);
    case (op)
      OPC_RD_COH, OPC_WR_UNIQUE, OPC_WR_NOSNP: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hn_pick_first.sv
module hn_pick_first #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  // Keep only the lowest set bit.
  assign gnt_o = req_i & (~req_i + N'(1));
  assign any_o = |req_i;
endmodule

// File: rtl/hn_hazard_slot.sv
module hn_hazard_slot
  import hn_ack_hazard_pkg::*;
#(
  parameter int LINE_W = 34,
  parameter int SRC_W  = 7,
  parameter int TXN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [TXN_W-1:0]  txn_i,
  input  logic              need_ack_i,
  input  logic              cmp_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              active_o,
  output logic              waiting_o,
  output logic [LINE_W-1:0] line_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [TXN_W-1:0]  txn_o
);
  slot_state_e       state_q;
  logic              need_q;
  logic [LINE_W-1:0] line_q;
  logic [SRC_W-1:0]  src_q;
  logic [TXN_W-1:0]  txn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      need_q  <= 1'b0;
      line_q  <= '0;
      src_q   <= '0;
      txn_q   <= '0;
    end else begin
      case (state_q)
        SLOT_IDLE: if (alloc_i) begin
          state_q <= SLOT_ACTIVE;
          need_q  <= need_ack_i;
          line_q  <= line_i;
          src_q   <= src_i;
          txn_q   <= txn_i;
        end
        SLOT_ACTIVE: if (cmp_i) state_q <= need_q ? SLOT_WAIT : SLOT_IDLE;
        SLOT_WAIT:   if (ack_i) state_q <= SLOT_IDLE;
        default:     state_q <= SLOT_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != SLOT_IDLE);
  assign active_o  = (state_q == SLOT_ACTIVE);
  assign waiting_o = (state_q == SLOT_WAIT);
  assign line_o    = line_q;
  assign src_o     = src_q;
  assign txn_o     = txn_q;

  p_alloc_into_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> state_q == SLOT_IDLE);

  p_wait_held_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_WAIT && !ack_i) |=> state_q == SLOT_WAIT);

  p_no_ack_class_retires_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_ACTIVE && cmp_i && !need_q) |=> state_q == SLOT_IDLE);

  p_ack_class_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_ACTIVE && cmp_i && need_q) |=> state_q == SLOT_WAIT);

endmodule

// File: rtl/hn_ack_hazard.sv
module hn_ack_hazard
  import hn_ack_hazard_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 40,
  parameter int SRC_W     = 7,
  parameter int TXN_W     = 8,
  parameter int LINE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_stall,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [TXN_W-1:0]  req_txn,
  input  logic              cmp_valid,
  input  logic [SRC_W-1:0]  cmp_src,
  input  logic [TXN_W-1:0]  cmp_txn,
  input  logic              ack_valid,
  input  logic [SRC_W-1:0]  ack_src,
  input  logic [TXN_W-1:0]  ack_txn,
  output logic              ack_err
);
  localparam int LINE_W = ADDR_W - LINE_BITS;

  logic [LINE_W-1:0]  req_line;
  logic               req_need;
  logic [ENTRIES-1:0] busy, active, waiting;
  logic [ENTRIES-1:0] hazard_hit, cmp_hit, ack_hit;
  logic [ENTRIES-1:0] alloc_sel, cmp_sel, ack_sel, alloc_vec;
  logic               any_free, any_cmp, any_ack, accept, err_q;
  logic               unused_lo;

  assign req_line  = req_addr[ADDR_W-1:LINE_BITS];
  assign unused_lo = &{1'b0, req_addr[LINE_BITS-1:0]};
  assign req_need  = opc_needs_ack(opc_class_e'(req_op));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic [LINE_W-1:0] line_s;
    logic [SRC_W-1:0]  src_s;
    logic [TXN_W-1:0]  txn_s;

    hn_hazard_slot #(.LINE_W(LINE_W), .SRC_W(SRC_W), .TXN_W(TXN_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_vec[i]),
      .line_i     (req_line),
      .src_i      (req_src),
      .txn_i      (req_txn),
      .need_ack_i (req_need),
      .cmp_i      (cmp_sel[i]),
      .ack_i      (ack_sel[i]),
      .busy_o     (busy[i]),
      .active_o   (active[i]),
      .waiting_o  (waiting[i]),
      .line_o     (line_s),
      .src_o      (src_s),
      .txn_o      (txn_s)
    );

    assign hazard_hit[i] = waiting[i] && (line_s == req_line);
    assign cmp_hit[i]    = cmp_valid && active[i] && (src_s == cmp_src) && (txn_s == cmp_txn);
    assign ack_hit[i]    = ack_valid && waiting[i] && (src_s == ack_src) && (txn_s == ack_txn);
  end

  hn_pick_first #(.N(ENTRIES)) u_pick_free (.req_i(~busy),   .gnt_o(alloc_sel), .any_o(any_free));
  hn_pick_first #(.N(ENTRIES)) u_pick_cmp  (.req_i(cmp_hit), .gnt_o(cmp_sel),   .any_o(any_cmp));
  hn_pick_first #(.N(ENTRIES)) u_pick_ack  (.req_i(ack_hit), .gnt_o(ack_sel),   .any_o(any_ack));

  assign req_ready = any_free && !(|hazard_hit);
  assign req_stall = req_valid && !req_ready;
  assign accept    = req_valid && req_ready;
  assign alloc_vec = alloc_sel & {ENTRIES{accept}};

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_q <= 1'b0;
    else if (ack_valid && !any_ack) err_q <= 1'b1;
  end
  assign ack_err = err_q;

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);

  p_single_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  p_stray_ack_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && $countones(ack_hit) == 0) |=> ack_err);

  p_unknown_cmp_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !any_cmp && !accept && !(|ack_sel)) |=> $stable(busy));

endmodule

// File: tb/hn_ack_hazard_bench.sv
module hn_ack_hazard_bench;
  localparam int ENTRIES = 8;
  localparam int ADDR_W  = 40;
  localparam int SRC_W   = 7;
  localparam int TXN_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_stall;
  logic [2:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SRC_W-1:0] req_src = '0, cmp_src = '0, ack_src = '0;
  logic [TXN_W-1:0] req_txn = '0, cmp_txn = '0, ack_txn = '0;
  logic cmp_valid = 1'b0, ack_valid = 1'b0, ack_err;

  always #5 clk = ~clk;

  hn_ack_hazard #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .TXN_W(TXN_W)) u_hn_ack_hazard (
    .clk, .rst_n, .req_valid, .req_ready, .req_stall, .req_op, .req_addr, .req_src, .req_txn,
    .cmp_valid, .cmp_src, .cmp_txn, .ack_valid, .ack_src, .ack_txn, .ack_err);

  typedef struct {
    longint line;
    int     src;
    int     txn;
    bit     need;
    bit     waiting;
  } rec_t;

  rec_t q[$];
  bit   exp_err;
  int   checks = 0;
  int   failures = 0;

  function automatic bit needs(int op);
    return (op == 2 || op == 3 || op == 4);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock of the model: compare outputs, then advance the model as the edge would.
  task automatic cyc(string tag);
    bit hz;
    bit exp_rdy;
    int a_idx;
    int c_idx;
    longint ln;
    #1;
    ln = longint'(req_addr >> 6);
    hz = 0;
    foreach (q[i]) if (q[i].waiting && q[i].line == ln) hz = 1;
    exp_rdy = (q.size() < ENTRIES) && !hz;
    chk(tag, "req_ready", int'(req_ready), int'(exp_rdy));
    chk(tag, "req_stall", int'(req_stall), int'(req_valid && !exp_rdy));
    chk(tag, "ack_err", int'(ack_err), int'(exp_err));
    a_idx = -1;
    c_idx = -1;
    if (ack_valid)
      foreach (q[i]) if (a_idx < 0 && q[i].waiting && q[i].src == int'(ack_src) && q[i].txn == int'(ack_txn)) a_idx = i;
    if (cmp_valid)
      foreach (q[i]) if (c_idx < 0 && !q[i].waiting && q[i].src == int'(cmp_src) && q[i].txn == int'(cmp_txn)) c_idx = i;
    if (ack_valid && a_idx < 0) exp_err = 1;
    if (c_idx >= 0 && q[c_idx].need) begin
      q[c_idx].waiting = 1;
      c_idx = -1;
    end
    if (a_idx >= 0 && c_idx >= 0) begin
      if (a_idx > c_idx) begin
        q.delete(a_idx);
        q.delete(c_idx);
      end else begin
        q.delete(c_idx);
        q.delete(a_idx);
      end
    end else if (a_idx >= 0) q.delete(a_idx);
    else if (c_idx >= 0) q.delete(c_idx);
    if (req_valid && exp_rdy) begin
      rec_t r;
      r.line = ln;
      r.src = int'(req_src);
      r.txn = int'(req_txn);
      r.need = needs(int'(req_op));
      r.waiting = 0;
      q.push_back(r);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic req(int op, longint addr, int src, int txn);
    req_valid = 1;
    req_op = 3'(op);
    req_addr = ADDR_W'(addr);
    req_src = SRC_W'(src);
    req_txn = TXN_W'(txn);
  endtask

  task automatic cmp(int src, int txn);
    cmp_valid = 1;
    cmp_src = SRC_W'(src);
    cmp_txn = TXN_W'(txn);
  endtask

  task automatic ack(int src, int txn);
    ack_valid = 1;
    ack_src = SRC_W'(src);
    ack_txn = TXN_W'(txn);
  endtask

  task automatic idle();
    req_valid = 0;
    cmp_valid = 0;
    ack_valid = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    q.delete();
    exp_err = 0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    #1;
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "err after reset", int'(ack_err), 0);
    cyc("R1");

    // R10 active-only line does not stall
    req(2, 40'h1000, 1, 1);
    cyc("R10");
    req(1, 40'h1008, 2, 5);
    #1;
    chk("R10", "ready on active line", int'(req_ready), 1);
    cyc("R10");
    idle();
    cmp(1, 1);
    cyc("R11");
    // R3/R4 waiting line stalls regardless of low bits; R2 read-once retires
    req(2, 40'h103F, 3, 3);
    cmp(2, 5);
    #1;
    chk("R3", "ready on waiting line", int'(req_ready), 0);
    chk("R4", "stall low bits ignored", int'(req_stall), 1);
    cyc("R3");
    cmp_valid = 0;
    cyc("R3");
    req(0, 40'h1040, 4, 4);
    #1;
    chk("R4", "next line ready", int'(req_ready), 1);
    cyc("R4");
    // R7 stray acknowledge
    req(2, 40'h1010, 3, 3);
    ack(9, 9);
    cyc("R7");
    ack_valid = 0;
    #1;
    chk("R7", "err set", int'(ack_err), 1);
    chk("R7", "line still held", int'(req_ready), 0);
    cyc("R7");
    // R5 / R11 real acknowledge
    ack(1, 1);
    #1;
    chk("R11", "ready same cycle as ack", int'(req_ready), 0);
    cyc("R11");
    ack_valid = 0;
    #1;
    chk("R5", "ready after ack", int'(req_ready), 1);
    cyc("R5");
    idle();
    cyc("R7");
    chk("R7", "err stays", int'(ack_err), 1);

    // R9 unknown completion
    do_reset();
    req(3, 40'h2000, 3, 7);
    cyc("R9");
    idle();
    cmp(6, 6);
    cyc("R9");
    cmp_valid = 0;
    req(0, 40'h2000, 4, 1);
    #1;
    chk("R9", "line not waiting", int'(req_ready), 1);
    chk("R9", "no error", int'(ack_err), 0);
    cyc("R9");
    // R8 early acknowledge
    idle();
    ack(3, 7);
    cyc("R8");
    idle();
    #1;
    chk("R8", "early ack err", int'(ack_err), 1);
    cmp(3, 7);
    cyc("R8");
    idle();
    req(1, 40'h2000, 5, 5);
    #1;
    chk("R8", "line waits after late cmp", int'(req_ready), 0);
    cyc("R8");
    idle();
    cyc("R8");

    // R6 full table
    do_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      req(0, 40'h10000 + longint'(i) * 64, 1, i);
      cyc("R6");
    end
    req(0, 40'h90000, 2, 0);
    #1;
    chk("R6", "full stalls", int'(req_stall), 1);
    cyc("R6");
    cmp(1, 3);
    #1;
    chk("R11", "ready same cycle as freeing cmp", int'(req_ready), 0);
    cyc("R11");
    cmp_valid = 0;
    #1;
    chk("R6", "ready after free", int'(req_ready), 1);
    cyc("R6");
    idle();

    // R2 opcode sweep
    do_reset();
    for (int op = 0; op < 8; op++) begin
      longint a;
      a = 40'h40000 + longint'(op) * 4096;
      idle();
      req(op, a, 1, op);
      cyc("R2");
      idle();
      cmp(1, op);
      cyc("R2");
      idle();
      req(0, a + 5, 2, op);
      #1;
      chk("R2", "class hold decision", int'(req_ready), int'(!needs(op)));
      cyc("R2");
      idle();
      if (needs(op)) begin
        ack(1, op);
        cyc("R5");
        idle();
      end else begin
        cmp(2, op);
        cyc("R2");
        idle();
      end
    end
    cyc("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule